// File: doc/BRIEF.md
# I2C SCL Baud-Rate Generator

This block sits beside an I2C master's bus engine and turns the system clock into a stream of single-cycle phase enables. The bus engine advances one sub-phase of the SCL waveform on each enable, and ten enables make one SCL period. The division ratio comes from a 7-bit baud word with two fields. A 4-bit linear field M divides by M+1. A 3-bit exponent field N divides by 2^(N+1). Each phase enable therefore arrives every (M+1)·2^(N+1) system clocks, and the SCL frequency is the system clock divided by 10·(M+1)·2^(N+1). Software picks M and N. This block only applies them.

The divider is two cascaded counters followed by a sub-phase sequencer. The sequencer reports the index of the current sub-phase and flags the tick that closes each SCL period. Writing a new baud word restarts every stage, so the new rate starts from a clean phase boundary. Deasserting the core enable holds the whole chain at zero, and no ticks come out while it is low.

Top module: `scl_rate_gen`

## Requirements
- R1: While running, `tick` is high for exactly one clock, and consecutive ticks are exactly P = (M+1)·2^(N+1) clocks apart.
- R2: M is taken from bits 6:3 of `baud_wdata` and contributes a linear factor of M+1 (M = 0..15).
- R3: N is taken from bits 2:0 of `baud_wdata` and contributes a factor of 2^(N+1) (N = 0..7). M=0, N=0 gives a tick every 2 clocks.
- R4: A clock edge that samples `baud_we` high loads the word and clears every stage. In the cycle after that edge `tick` is 0 and `phase` is 0, and the first tick at the new rate rises exactly P clocks after that edge, even when the write lands in the middle of a count. Without a write, the stored word does not change.
- R5: While `core_en` is low, `tick` and `period_end` stay 0 and `phase` stays 0. A baud write is still stored during this time. The first tick rises P clocks after the last edge that sampled `core_en` low.
- R6: `phase` counts the ticks since the last restart modulo 10. It is 0 before the first tick and equals k mod 10 from the cycle of the k-th tick onward.
- R7: `period_end` is high together with the 10th, 20th, … tick after a restart and is low at every other time, so one SCL period spans 10·P clocks.
- R8: Directly after reset, `tick`, `period_end` and `phase` are 0 and the stored baud word is 0 (M=0, N=0, P=2).
- R9: The slowest setting, M=15 and N=7, gives a tick every 4096 clocks and a `period_end` every 40960 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| core_en | input | 1 | Core enable; low holds the divider chain at zero |
| baud_we | input | 1 | Load strobe for the baud word |
| baud_wdata | input | 7 | Baud word: M in bits 6:3, N in bits 2:0 |
| tick | output | 1 | One-cycle sub-phase enable, ten per SCL period |
| phase | output | 4 | Sub-phase index, 0..9 |
| period_end | output | 1 | High with the tick that completes an SCL period |

## Verification
Several properties are checked on every cycle: the linear counter never passes M, the exponent counter never sets a bit above N, a tick never lasts two cycles, the sub-phase index stays below ten, `period_end` only appears together with a tick, and a write or a low enable silences the outputs on the next cycle. The exact spacing between ticks for each (M, N) pair can only be shown by the bench, which counts clocks between ticks. The same holds for the delay from a mid-count rewrite, the delay after the enable is raised, and the position of the period flag on every tenth tick.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  // Field widths of the baud word and sub-phases per SCL period.
  localparam int unsigned LIN_FIELD_W    = 4;
  localparam int unsigned EXP_FIELD_W    = 3;
  localparam int unsigned SUBTICKS_PER_SCL = 10;
endpackage

// File: rtl/scl_baud_reg.sv
module scl_baud_reg #(
  parameter int unsigned M_W = 4,
  parameter int unsigned N_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [M_W+N_W-1:0] wr_data,
  output logic [M_W-1:0]     lin_sel,
  output logic [N_W-1:0]     exp_sel
);
  localparam int unsigned BW = M_W + N_W;

  logic [BW-1:0] baud_q, baud_d;

  always_comb begin
    baud_d = baud_q;
    if (wr_en) baud_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) baud_q <= '0;
    else        baud_q <= baud_d;
  end

  // Linear field sits above the exponent field.
  assign lin_sel = baud_q[BW-1:N_W];
  assign exp_sel = baud_q[N_W-1:0];

  // R4: the stored word only moves on a write.
  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(baud_q));
endmodule

// File: rtl/scl_lin_div.sv
module scl_lin_div #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap = !clear && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clear || wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the linear stage never counts beyond M.
  assert_lin_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
endmodule

// File: rtl/scl_pow_div.sv
module scl_pow_div #(
  parameter int unsigned N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  input  logic [N_W-1:0] exp_sel,
  output logic           wrap
);
  // The widest ratio 2^(2^N_W) needs 2^N_W counter bits.
  localparam int unsigned POW_W = 1 << N_W;

  logic [POW_W-1:0] cnt_q, cnt_d;
  logic [N_W:0]     shamt;
  logic [POW_W-1:0] live_mask;

  // Bits 0..N of the counter are live; the count ends when all are set.
  assign shamt     = {1'b0, exp_sel} + {{N_W{1'b0}}, 1'b1};
  assign live_mask = ~({POW_W{1'b1}} << shamt);
  assign wrap      = !clear && step && (&(cnt_q | ~live_mask));

  always_comb begin
    cnt_d = cnt_q;
    if (clear || wrap) cnt_d = '0;
    else if (step)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: no counter bit above position N is ever set.
  assert_pow_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q & ~live_mask) == '0);
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int unsigned PHASES = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      adv,
  output logic                      tick_o,
  output logic [$clog2(PHASES)-1:0] phase_o,
  output logic                      end_o
);
  localparam int unsigned PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic            tick_q, tick_d;
  logic            end_q, end_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            at_last;

  assign at_last = (ph_q == PH_LAST);

  always_comb begin
    tick_d = 1'b0;
    end_d  = 1'b0;
    ph_d   = ph_q;
    if (clear) begin
      ph_d = '0;
    end else if (adv) begin
      tick_d = 1'b1;
      end_d  = at_last;
      ph_d   = at_last ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      end_q  <= 1'b0;
      ph_q   <= '0;
    end else begin
      tick_q <= tick_d;
      end_q  <= end_d;
      ph_q   <= ph_d;
    end
  end

  assign tick_o  = tick_q;
  assign phase_o = ph_q;
  assign end_o   = end_q;

  // R1: the smallest ratio is 2, so a tick never lasts two cycles.
  assert_single_cycle_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  // R6: the sub-phase index stays within one SCL period.
  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_LAST);
  // R7: the period flag only comes with a tick that wrapped the index.
  assert_end_with_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (tick_q && ph_q == '0));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int unsigned M_W    = LIN_FIELD_W,
  parameter int unsigned N_W    = EXP_FIELD_W,
  parameter int unsigned PHASES = SUBTICKS_PER_SCL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      core_en,
  input  logic                      baud_we,
  input  logic [M_W+N_W-1:0]        baud_wdata,
  output logic                      tick,
  output logic [$clog2(PHASES)-1:0] phase,
  output logic                      period_end
);
  logic [M_W-1:0] lin_sel;
  logic [N_W-1:0] exp_sel;
  logic           restart;
  logic           lin_wrap;
  logic           pow_wrap;

  // Any write or a low enable restarts the whole chain.
  assign restart = baud_we || !core_en;

  scl_baud_reg #(.M_W(M_W), .N_W(N_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (baud_we),
    .wr_data (baud_wdata),
    .lin_sel (lin_sel),
    .exp_sel (exp_sel)
  );

  scl_lin_div #(.W(M_W)) u_lin (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .limit (lin_sel),
    .wrap  (lin_wrap)
  );

  scl_pow_div #(.N_W(N_W)) u_pow (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart),
    .step    (lin_wrap),
    .exp_sel (exp_sel),
    .wrap    (pow_wrap)
  );

  scl_phase_seq #(.PHASES(PHASES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart),
    .adv     (pow_wrap),
    .tick_o  (tick),
    .phase_o (phase),
    .end_o   (period_end)
  );

  // R5: a low enable silences the outputs on the next cycle.
  assert_quiet_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> (!tick && !period_end && phase == '0));
  // R4: a write restarts the sequence from sub-phase zero.
  assert_write_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    baud_we |=> (!tick && phase == '0));
endmodule

// File: tb/scl_rate_gen_tb.sv
`timescale 1ns/1ps
module scl_rate_gen_tb;
  logic       clk;
  logic       rst_n;
  logic       core_en;
  logic       baud_we;
  logic [6:0] baud_wdata;
  logic       tick;
  logic [3:0] phase;
  logic       period_end;

  int checks = 0;
  int errors = 0;

  scl_rate_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_en    (core_en),
    .baud_we    (baud_we),
    .baud_wdata (baud_wdata),
    .tick       (tick),
    .phase      (phase),
    .period_end (period_end)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  // Stimulus vectors: M, N, expected clocks between ticks.
  localparam int NV = 8;
  localparam int VM [NV] = '{0, 1, 0, 3, 15, 0, 5, 15};
  localparam int VN [NV] = '{0, 0, 1, 2, 0, 7, 3, 7};
  localparam int VP [NV] = '{2, 4, 4, 32, 32, 256, 96, 4096};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_baud(input int m, input int n);
    @(negedge clk);
    baud_we    = 1'b1;
    baud_wdata = {m[3:0], n[2:0]};
    @(negedge clk);
    baud_we    = 1'b0;
  endtask

  // Counts clock edges until tick is seen high (sampled at falling edges).
  task automatic wait_tick(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!tick && c < 50000);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    int cnt;
    rst_n = 1'b0; core_en = 1'b0; baud_we = 1'b0; baud_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 tick after reset", tick, 0);
    check("R8 phase after reset", phase, 0);
    check("R8 period_end after reset", period_end, 0);

    // R8: default word gives P = 2 once enabled.
    core_en = 1'b1;
    wait_tick(c);
    check("R8 default spacing", c, 2);

    // Table walk: R1 R2 R3 R4 R6.
    for (int i = 0; i < NV; i++) begin
      write_baud(VM[i], VN[i]);
      check("R4 tick right after write", tick, 0);
      check("R4 phase right after write", phase, 0);
      wait_tick(c);
      check($sformatf("R4 first tick M=%0d N=%0d", VM[i], VN[i]), c, VP[i]);
      check("R6 phase at first tick", phase, 1);
      wait_tick(c);
      check($sformatf("R1 R2 R3 spacing M=%0d N=%0d", VM[i], VN[i]), c, VP[i]);
    end

    // R4: rewrite in the middle of a count.
    write_baud(3, 2);
    repeat (10) @(negedge clk);
    write_baud(3, 2);
    wait_tick(c);
    check("R4 mid-count restart", c, 32);

    // R5: disable, write while disabled, re-enable.
    write_baud(1, 0);
    @(negedge clk);
    core_en = 1'b0;
    write_baud(1, 1);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick || period_end) cnt++;
    end
    check("R5 no ticks while disabled", cnt, 0);
    check("R5 phase while disabled", phase, 0);
    core_en = 1'b1;
    wait_tick(c);
    check("R5 first tick after enable", c, 8);

    // R6 R7: phase and period flag over 25 ticks at P = 2.
    write_baud(0, 0);
    cnt = 0;
    for (int k = 1; k <= 25; k++) begin
      wait_tick(c);
      check($sformatf("R6 phase at tick %0d", k), phase, k % 10);
      check($sformatf("R7 period_end at tick %0d", k), period_end, (k % 10 == 0) ? 1 : 0);
      if (c != 2) cnt++;
    end
    check("R1 spacing over run", cnt, 0);

    // R9: slowest setting, one full SCL period.
    write_baud(15, 7);
    c = 0;
    cnt = 0;
    do begin
      @(negedge clk);
      c++;
      if (tick) cnt++;
    end while (!period_end && c < 50000);
    check("R9 clocks per SCL period", c, 40960);
    check("R9 ticks per SCL period", cnt, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule